// File: doc/BRIEF.md
# Dual Output Fast Read Engine

This block is the device-side read path of a serial flash target. While the chip select is low it collects a command byte and a 24-bit byte address from the serial input pin, both most significant bit first and sampled on rising serial clock edges. It then streams bytes from a synchronous memory read port, starting at that address and moving to the next higher address after every byte. The stream runs as long as the master keeps clocking and wraps from the top of the array to address zero.

Three read commands are accepted. Code 03h starts data right after the address. Code 0Bh inserts eight dummy clocks and sends one bit per falling clock edge on the output pin. Code 3Bh also inserts eight dummy clocks, but sends two bits per falling edge: the odd bits go on the output pin and the even bits on the bidirectional pin, which the block drives once the data phase begins. A command that arrives while the array reports busy is ignored for the whole selection.

All serial pins are oversampled by the fast system clock through a synchronizer, so the serial clock half period must be at least four system clocks. Each pin has an output enable for an external tristate buffer. The memory port returns data one system clock after a read strobe.

Top module: `dual_fast_read_engine`

## Requirements
- R1: The command byte and the 24 address bits are sampled on rising serial clock edges, MSB first; code 03h, 0Bh or 3Bh starts a read, and the low MEM_AW address bits select the first byte.
- R2: Codes 0Bh and 3Bh insert exactly eight dummy clocks after the address, and the input pin value during those clocks has no effect on the data returned.
- R3: With code 03h the first data bit appears on the falling edge right after the 32nd rising edge, with no dummy clocks.
- R4: In single-output mode each falling edge presents the next bit on the output pin, bit 7 of each byte first, and the bidirectional pin stays released.
- R5: In dual-output mode each falling edge presents two bits: the output pin carries bits 7, 5, 3, 1 and the bidirectional pin carries bits 6, 4, 2, 0 of the same byte, in that order, so one byte takes four clocks.
- R6: After each byte the address moves to the next higher byte with no page limit, and wraps from 2^MEM_AW-1 to 0.
- R7: Output pin values change only after falling serial clock edges and are stable through each high half period.
- R8: Both output enables are low out of reset, while chip select is high, and through the whole command, address and dummy phase; they rise at the first data falling edge.
- R9: If busy is high when the eighth command bit is sampled, or the code is not a read code, the selection is ignored: no output enable and no memory read until chip select rises; busy rising after a read was accepted does not disturb it.
- R10: Raising chip select after any bit ends the transfer, and the next selection starts a fresh command.
- R11: Serial clock idling low (mode 0) or high (mode 3) at chip select edges gives the same command decoding and data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| spi_sclk | input | 1 | Serial clock from the master |
| spi_cs_n | input | 1 | Active-low chip select |
| spi_dio_in | input | 1 | Input value of the bidirectional data pin |
| busy | input | 1 | High while the array is programming or erasing |
| mem_rdata | input | 8 | Memory read data, valid one clock after mem_rd |
| spi_do | output | 1 | Output data pin value |
| spi_do_oe | output | 1 | Output enable for the output data pin |
| spi_dio_out | output | 1 | Output value for the bidirectional pin |
| spi_dio_oe | output | 1 | Output enable for the bidirectional pin |
| mem_addr | output | MEM_AW | Memory byte address |
| mem_rd | output | 1 | One-cycle memory read strobe |

## Verification
The assertions watch, on every system clock, that the output data value moves only in the cycle after a detected falling edge, that each memory read after the first of a command targets the previous address plus one, that an ignored selection never drives a pin or reads memory, and that the bidirectional pin is only driven in dual mode. Whether the right bits land in the right order on each pin, that dummy values and idle clock level make no difference, that the address wraps at the top of the array and that an early chip select release leaves a clean next command can only be shown by the bench's scenarios, which decode the pins like a master and compare with a model of the memory.

// File: rtl/drd_pkg.sv
`timescale 1ns/1ps
package drd_pkg;
  localparam int OPC_W      = 8;
  localparam int ADDR_W     = 24;
  localparam int DUMMY_CLKS = 8;
  localparam int CNT_W      = $clog2(ADDR_W);

  localparam logic [OPC_W-1:0] OPC_READ      = 8'h03;
  localparam logic [OPC_W-1:0] OPC_FAST      = 8'h0B;
  localparam logic [OPC_W-1:0] OPC_FAST_DUAL = 8'h3B;

  typedef enum logic [2:0] {
    PH_CMD    = 3'd0,
    PH_ADDR   = 3'd1,
    PH_DUMMY  = 3'd2,
    PH_DATA   = 3'd3,
    PH_IGNORE = 3'd4
  } phase_e;
endpackage

// File: rtl/drd_reset_sync.sv
`timescale 1ns/1ps
module drd_reset_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  assign sync_d     = {sync_q[STAGES-2:0], 1'b1};
  assign rst_n_sync = sync_q[STAGES-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end
endmodule

// File: rtl/drd_pin_sync.sv
`timescale 1ns/1ps
module drd_pin_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk,
  input  logic cs_n,
  input  logic dio,
  output logic cs_act,
  output logic rise_ev,
  output logic fall_ev,
  output logic din
);
  localparam logic [2:0] SYNC_RST = 3'b100;

  logic [2:0] stage_q [STAGES];
  logic [2:0] stage_d [STAGES];
  logic       sclk_prev_q;
  logic       sclk_s;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      assign stage_d[g] = {cs_n, sclk, dio};
    end else begin : g_next
      assign stage_d[g] = stage_q[g-1];
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= SYNC_RST;
      else        stage_q[g] <= stage_d[g];
    end
  end

  assign cs_act = ~stage_q[STAGES-1][2];
  assign sclk_s = stage_q[STAGES-1][1];
  assign din    = stage_q[STAGES-1][0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sclk_prev_q <= 1'b0;
    else        sclk_prev_q <= sclk_s;
  end

  assign rise_ev = cs_act &  sclk_s & ~sclk_prev_q;
  assign fall_ev = cs_act & ~sclk_s &  sclk_prev_q;
endmodule

// File: rtl/drd_cmd_ctrl.sv
`timescale 1ns/1ps
module drd_cmd_ctrl
  import drd_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              rise_ev,
  input  logic              din,
  input  logic              busy,
  output phase_e            phase,
  output logic              dual_mode,
  output logic              start_pulse,
  output logic [ADDR_W-1:0] start_addr
);
  phase_e             phase_q, phase_d;
  logic [CNT_W-1:0]   cnt_q, cnt_d;
  logic [ADDR_W-2:0]  sh_q, sh_d;
  logic               dual_q, dual_d;
  logic               fast_q, fast_d;
  logic [OPC_W-1:0]   opcode;

  assign opcode     = {sh_q[OPC_W-2:0], din};
  assign start_addr = {sh_q, din};
  assign phase      = phase_q;
  assign dual_mode  = dual_q;

  always_comb begin
    phase_d     = phase_q;
    cnt_d       = cnt_q;
    sh_d        = sh_q;
    dual_d      = dual_q;
    fast_d      = fast_q;
    start_pulse = 1'b0;
    if (!cs_act) begin
      phase_d = PH_CMD;
      cnt_d   = '0;
      dual_d  = 1'b0;
      fast_d  = 1'b0;
    end else if (rise_ev) begin
      sh_d = {sh_q[ADDR_W-3:0], din};
      unique case (phase_q)
        PH_CMD: begin
          if (cnt_q == CNT_W'(OPC_W-1)) begin
            cnt_d = '0;
            if (busy) begin
              phase_d = PH_IGNORE;
            end else begin
              unique case (opcode)
                OPC_READ:      begin phase_d = PH_ADDR; fast_d = 1'b0; dual_d = 1'b0; end
                OPC_FAST:      begin phase_d = PH_ADDR; fast_d = 1'b1; dual_d = 1'b0; end
                OPC_FAST_DUAL: begin phase_d = PH_ADDR; fast_d = 1'b1; dual_d = 1'b1; end
                default:       phase_d = PH_IGNORE;
              endcase
            end
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_ADDR: begin
          if (cnt_q == CNT_W'(ADDR_W-1)) begin
            cnt_d       = '0;
            start_pulse = 1'b1;
            phase_d     = fast_q ? PH_DUMMY : PH_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        PH_DUMMY: begin
          if (cnt_q == CNT_W'(DUMMY_CLKS-1)) begin
            cnt_d   = '0;
            phase_d = PH_DATA;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_CMD;
      cnt_q   <= '0;
      sh_q    <= '0;
      dual_q  <= 1'b0;
      fast_q  <= 1'b0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      sh_q    <= sh_d;
      dual_q  <= dual_d;
      fast_q  <= fast_d;
    end
  end
endmodule

// File: rtl/drd_data_path.sv
`timescale 1ns/1ps
module drd_data_path
  import drd_pkg::*;
#(
  parameter int MEM_AW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_act,
  input  logic              fall_ev,
  input  logic              data_phase,
  input  logic              dual_mode,
  input  logic              start_pulse,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [7:0]        mem_rdata,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_rd,
  output logic              do_bit,
  output logic              dio_bit,
  output logic              drive
);
  localparam int SLOT_W = 3;

  logic [MEM_AW-1:0] addr_q, addr_d;
  logic              rd_q, rd_d;
  logic              rd_d1_q;
  logic [7:0]        buf_q, buf_d;
  logic [7:0]        sh_q, sh_d;
  logic [SLOT_W-1:0] slot_q, slot_d;
  logic              do_q, do_d;
  logic              dio_q, dio_d;
  logic              drive_q, drive_d;
  logic [SLOT_W-1:0] last_slot;
  logic              unused_addr_hi;

  assign unused_addr_hi = ^start_addr[ADDR_W-1:MEM_AW];
  assign last_slot      = dual_mode ? SLOT_W'(3) : SLOT_W'(7);

  always_comb begin
    addr_d  = addr_q;
    rd_d    = 1'b0;
    buf_d   = buf_q;
    sh_d    = sh_q;
    slot_d  = slot_q;
    do_d    = do_q;
    dio_d   = dio_q;
    drive_d = drive_q;
    if (rd_d1_q) buf_d = mem_rdata;
    if (start_pulse) begin
      addr_d = start_addr[MEM_AW-1:0];
      rd_d   = 1'b1;
    end
    if (!cs_act || !data_phase) begin
      slot_d  = '0;
      drive_d = 1'b0;
    end else if (fall_ev) begin
      drive_d = 1'b1;
      if (slot_q == '0) begin
        do_d   = buf_q[7];
        dio_d  = buf_q[6];
        sh_d   = dual_mode ? (buf_q << 2) : (buf_q << 1);
        addr_d = addr_q + 1'b1;
        rd_d   = 1'b1;
      end else begin
        do_d  = sh_q[7];
        dio_d = sh_q[6];
        sh_d  = dual_mode ? (sh_q << 2) : (sh_q << 1);
      end
      slot_d = (slot_q == last_slot) ? '0 : slot_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      rd_q    <= 1'b0;
      rd_d1_q <= 1'b0;
      buf_q   <= '0;
      sh_q    <= '0;
      slot_q  <= '0;
      do_q    <= 1'b0;
      dio_q   <= 1'b0;
      drive_q <= 1'b0;
    end else begin
      addr_q  <= addr_d;
      rd_q    <= rd_d;
      rd_d1_q <= rd_q;
      buf_q   <= buf_d;
      sh_q    <= sh_d;
      slot_q  <= slot_d;
      do_q    <= do_d;
      dio_q   <= dio_d;
      drive_q <= drive_d;
    end
  end

  assign mem_addr = addr_q;
  assign mem_rd   = rd_q;
  assign do_bit   = do_q;
  assign dio_bit  = dio_q;
  assign drive    = drive_q;
endmodule

// File: rtl/dual_fast_read_engine.sv
`timescale 1ns/1ps
module dual_fast_read_engine
  import drd_pkg::*;
#(
  parameter int MEM_AW      = 12,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              spi_sclk,
  input  logic              spi_cs_n,
  input  logic              spi_dio_in,
  input  logic              busy,
  input  logic [7:0]        mem_rdata,
  output logic              spi_do,
  output logic              spi_do_oe,
  output logic              spi_dio_out,
  output logic              spi_dio_oe,
  output logic [MEM_AW-1:0] mem_addr,
  output logic              mem_rd
);
  logic              rst_n_sync;
  logic              cs_act;
  logic              rise_ev;
  logic              fall_ev;
  logic              din;
  phase_e            phase;
  logic              dual_mode;
  logic              start_pulse;
  logic [ADDR_W-1:0] start_addr;
  logic              data_phase;
  logic              drive;

  drd_reset_sync #(.STAGES(2)) rst_sync_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  drd_pin_sync #(.STAGES(SYNC_STAGES)) pin_sync_i (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .sclk    (spi_sclk),
    .cs_n    (spi_cs_n),
    .dio     (spi_dio_in),
    .cs_act  (cs_act),
    .rise_ev (rise_ev),
    .fall_ev (fall_ev),
    .din     (din)
  );

  drd_cmd_ctrl ctrl_i (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .cs_act      (cs_act),
    .rise_ev     (rise_ev),
    .din         (din),
    .busy        (busy),
    .phase       (phase),
    .dual_mode   (dual_mode),
    .start_pulse (start_pulse),
    .start_addr  (start_addr)
  );

  assign data_phase = (phase == PH_DATA);

  drd_data_path #(.MEM_AW(MEM_AW)) data_i (
    .clk         (clk),
    .rst_n       (rst_n_sync),
    .cs_act      (cs_act),
    .fall_ev     (fall_ev),
    .data_phase  (data_phase),
    .dual_mode   (dual_mode),
    .start_pulse (start_pulse),
    .start_addr  (start_addr),
    .mem_rdata   (mem_rdata),
    .mem_addr    (mem_addr),
    .mem_rd      (mem_rd),
    .do_bit      (spi_do),
    .dio_bit     (spi_dio_out),
    .drive       (drive)
  );

  assign spi_do_oe  = drive & ~spi_cs_n;
  assign spi_dio_oe = drive & dual_mode & ~spi_cs_n;
endmodule

// File: rtl/drd_checker.sv
`timescale 1ns/1ps
module drd_checker
  import drd_pkg::*;
#(
  parameter int MEM_AW = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              fall_ev,
  input logic              start_pulse,
  input phase_e            phase,
  input logic              dual_mode,
  input logic              spi_do,
  input logic              spi_do_oe,
  input logic              spi_dio_oe,
  input logic [MEM_AW-1:0] mem_addr,
  input logic              mem_rd
);
  p_do_moves_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !fall_ev |=> $stable(spi_do));

  p_addr_step_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_rd && !$past(start_pulse)) |-> (mem_addr == MEM_AW'($past(mem_addr) + MEM_AW'(1))));

  p_ignored_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_IGNORE) |-> (!spi_do_oe && !spi_dio_oe && !mem_rd));

  p_dio_drive_dual_r5: assert property (@(posedge clk) disable iff (!rst_n)
    spi_dio_oe |-> (dual_mode && spi_do_oe));

  p_no_drive_header_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == PH_CMD || phase == PH_ADDR || phase == PH_DUMMY) |-> !spi_do_oe);
endmodule

bind dual_fast_read_engine drd_checker #(.MEM_AW(MEM_AW)) chk_i (
  .clk         (clk),
  .rst_n       (rst_n),
  .fall_ev     (fall_ev),
  .start_pulse (start_pulse),
  .phase       (phase),
  .dual_mode   (dual_mode),
  .spi_do      (spi_do),
  .spi_do_oe   (spi_do_oe),
  .spi_dio_oe  (spi_dio_oe),
  .mem_addr    (mem_addr),
  .mem_rd      (mem_rd)
);

// File: tb/dual_fast_read_engine_tb_top.sv
`timescale 1ns/1ps
module dual_fast_read_engine_tb_top;
  localparam int MEM_AW = 12;
  localparam int HALF   = 6;
  localparam int LIMIT  = 100000;

  logic              clk;
  logic              rst_n;
  logic              spi_sclk;
  logic              spi_cs_n;
  logic              spi_dio_in;
  logic              busy;
  logic [7:0]        mem_rdata;
  logic              spi_do;
  logic              spi_do_oe;
  logic              spi_dio_out;
  logic              spi_dio_oe;
  logic [MEM_AW-1:0] mem_addr;
  logic              mem_rd;

  int  n_checks;
  int  n_err;
  int  rd_pulses;
  bit  done;
  logic s_do, s_dio, s_doe, s_dioe, h_do, h_dio;

  initial clk = 1'b0;
  always #2 clk = ~clk;

  dual_fast_read_engine #(.MEM_AW(MEM_AW)) dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .spi_sclk    (spi_sclk),
    .spi_cs_n    (spi_cs_n),
    .spi_dio_in  (spi_dio_in),
    .busy        (busy),
    .mem_rdata   (mem_rdata),
    .spi_do      (spi_do),
    .spi_do_oe   (spi_do_oe),
    .spi_dio_out (spi_dio_out),
    .spi_dio_oe  (spi_dio_oe),
    .mem_addr    (mem_addr),
    .mem_rd      (mem_rd)
  );

  function automatic logic [7:0] mem_byte(input logic [MEM_AW-1:0] a);
    logic [7:0] lo;
    logic [7:0] hi;
    lo = a[7:0];
    hi = 8'(a >> 8);
    return (lo * 8'd37 + 8'd91) ^ {hi[3:0], hi[3:0]};
  endfunction

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem_byte(mem_addr);
  end

  always @(posedge clk) begin
    if (mem_rd) rd_pulses <= rd_pulses + 1;
  end

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic xfer_bit(input logic din);
    spi_sclk   = 1'b0;
    spi_dio_in = din;
    wait_clk(HALF);
    s_do   = spi_do;
    s_dio  = spi_dio_out;
    s_doe  = spi_do_oe;
    s_dioe = spi_dio_oe;
    spi_sclk = 1'b1;
    wait_clk(HALF);
    h_do  = spi_do;
    h_dio = spi_dio_out;
  endtask

  task automatic start_sel(input bit m3);
    spi_sclk = m3;
    wait_clk(HALF);
    spi_cs_n = 1'b0;
    wait_clk(HALF);
  endtask

  task automatic end_sel(input bit m3, input string tag);
    if (!m3) begin
      spi_sclk = 1'b0;
      wait_clk(HALF);
    end
    spi_cs_n = 1'b1;
    wait_clk(1);
    chk(!spi_do_oe && !spi_dio_oe, {tag, " R8 enables low after chip select rises"},
        {spi_do_oe, spi_dio_oe}, 32'h0);
    wait_clk(2 * HALF);
  endtask

  task automatic send_byte(input logic [7:0] b, inout bit drove);
    for (int i = 7; i >= 0; i--) begin
      xfer_bit(b[i]);
      if (s_doe || s_dioe) drove = 1'b1;
    end
  endtask

  task automatic read_seq(input logic [7:0] opc, input logic [23:0] addr, input logic [7:0] dummy,
                          input int nbytes, input bit m3, input bit busy_late, input string tag);
    bit drove;
    bit unstable;
    bit oe_bad;
    bit dual;
    logic [7:0] got;
    logic [7:0] exp;
    logic [MEM_AW-1:0] a;
    drove    = 1'b0;
    unstable = 1'b0;
    oe_bad   = 1'b0;
    dual     = (opc == 8'h3B);
    start_sel(m3);
    send_byte(opc, drove);
    if (busy_late) busy = 1'b1;
    send_byte(addr[23:16], drove);
    send_byte(addr[15:8], drove);
    send_byte(addr[7:0], drove);
    if (opc != 8'h03) send_byte(dummy, drove);
    chk(!drove, {tag, " R8 no drive before data"}, {31'd0, drove}, 32'h0);
    for (int k = 0; k < nbytes; k++) begin
      a   = addr[MEM_AW-1:0] + MEM_AW'(k);
      exp = mem_byte(a);
      got = '0;
      if (dual) begin
        for (int j = 0; j < 4; j++) begin
          xfer_bit(1'b0);
          got[7-2*j] = s_do;
          got[6-2*j] = s_dio;
          if (h_do !== s_do || h_dio !== s_dio) unstable = 1'b1;
          if (!s_doe || !s_dioe) oe_bad = 1'b1;
        end
      end else begin
        for (int i = 7; i >= 0; i--) begin
          xfer_bit(1'b0);
          got[i] = s_do;
          if (h_do !== s_do) unstable = 1'b1;
          if (!s_doe || s_dioe) oe_bad = 1'b1;
        end
      end
      chk(got === exp, $sformatf("%s byte %0d addr %h", tag, k, a), {24'd0, got}, {24'd0, exp});
    end
    chk(!unstable, {tag, " R7 outputs stable in high half"}, {31'd0, unstable}, 32'h0);
    chk(!oe_bad, {tag, dual ? " R5 both pins driven" : " R4 only output pin driven"},
        {31'd0, oe_bad}, 32'h0);
    end_sel(m3, tag);
    busy = 1'b0;
  endtask

  task automatic t_reset();
    chk(!spi_do_oe && !spi_dio_oe, "R8 enables low after reset", {spi_do_oe, spi_dio_oe}, 32'h0);
    chk(rd_pulses == 0, "R8 no memory read after reset", rd_pulses, 32'h0);
  endtask

  task automatic t_ignored(input logic [7:0] opc, input bit bsy, input string tag);
    bit drove;
    int r0;
    drove = 1'b0;
    r0    = rd_pulses;
    busy  = bsy;
    start_sel(1'b0);
    send_byte(opc, drove);
    send_byte(8'h00, drove);
    send_byte(8'h01, drove);
    send_byte(8'h00, drove);
    send_byte(8'h00, drove);
    send_byte(8'h00, drove);
    send_byte(8'h00, drove);
    chk(!drove, {tag, " R9 ignored selection drives nothing"}, {31'd0, drove}, 32'h0);
    chk(rd_pulses == r0, {tag, " R9 ignored selection reads nothing"}, rd_pulses - r0, 32'h0);
    end_sel(1'b0, tag);
    busy = 1'b0;
  endtask

  task automatic t_early_end();
    bit drove;
    drove = 1'b0;
    start_sel(1'b0);
    send_byte(8'h0B, drove);
    send_byte(8'h00, drove);
    send_byte(8'h00, drove);
    send_byte(8'h40, drove);
    send_byte(8'h00, drove);
    for (int i = 0; i < 3; i++) xfer_bit(1'b0);
    end_sel(1'b0, "R10 stop mid byte");
    read_seq(8'h3B, 24'h000123, 8'h00, 2, 1'b0, 1'b0, "R10 fresh dual after mid-byte stop");
    start_sel(1'b0);
    for (int i = 0; i < 5; i++) xfer_bit(1'b1);
    end_sel(1'b0, "R10 stop inside command byte");
    read_seq(8'h0B, 24'h000777, 8'h00, 2, 1'b0, 1'b0, "R10 fresh single after partial command");
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
  endtask

  initial begin : watchdog
    repeat (LIMIT) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=below %0d cycles", LIMIT, LIMIT);
      summary();
      $finish;
    end
  end

  initial begin
    n_checks   = 0;
    n_err      = 0;
    rd_pulses  = 0;
    done       = 1'b0;
    mem_rdata  = '0;
    rst_n      = 1'b0;
    spi_sclk   = 1'b0;
    spi_cs_n   = 1'b1;
    spi_dio_in = 1'b0;
    busy       = 1'b0;
    wait_clk(5);
    rst_n = 1'b1;
    wait_clk(5);
    t_reset();
    read_seq(8'h0B, 24'h000010, 8'h00, 4, 1'b0, 1'b0, "R1 R4 single fast read");
    read_seq(8'h0B, 24'h000010, 8'hFF, 4, 1'b0, 1'b0, "R2 dummy ones ignored");
    read_seq(8'h0B, 24'h000010, 8'hA5, 2, 1'b0, 1'b0, "R2 dummy mixed ignored");
    read_seq(8'h3B, 24'h0002C4, 8'h00, 4, 1'b0, 1'b0, "R5 dual fast read");
    read_seq(8'h03, 24'h000555, 8'h00, 3, 1'b0, 1'b0, "R3 plain read no dummy");
    read_seq(8'h3B, 24'h123FFE, 8'h00, 4, 1'b0, 1'b0, "R6 dual wrap at top");
    read_seq(8'h0B, 24'h00FFFF, 8'h3C, 3, 1'b0, 1'b0, "R6 single wrap at top");
    t_ignored(8'h0B, 1'b1, "busy fast read");
    t_ignored(8'h3B, 1'b1, "busy dual read");
    t_ignored(8'h9F, 1'b0, "unknown code");
    read_seq(8'h3B, 24'h000200, 8'h00, 3, 1'b0, 1'b1, "R9 busy after accept no effect");
    t_early_end();
    read_seq(8'h3B, 24'h0002C4, 8'h00, 4, 1'b1, 1'b0, "R11 mode 3 dual");
    read_seq(8'h0B, 24'h000010, 8'h00, 3, 1'b1, 1'b0, "R11 mode 3 single");
    read_seq(8'h03, 24'h000555, 8'h00, 2, 1'b1, 1'b0, "R11 mode 3 plain");
    done = 1'b1;
    summary();
    $finish;
  end
endmodule